// File: doc/BRIEF.md
# Oversampling UART Receiver with Address Filter

This block receives asynchronous serial frames on a single line. It is paced by a one-cycle tick enable that pulses sixteen times per bit period; the baud-rate source lives outside. A frame is a low start bit, then 8 or 9 data bits sent least-significant first, then a stop bit. The line is first resynchronized by two flops. Each bit, including the start bit, is resolved by a two-of-three vote over the samples taken at ticks 7, 8 and 9 of the bit. A start bit that does not vote low is discarded as noise.

A finished frame is copied from the shift register into a holding register, and in 9-bit mode into a separate ninth-bit register. A receive-done flag is raised at the same time. While the flag stays set, later frames are still shifted in but never reach the holding registers. In 9-bit mode an address filter can be turned on. It drops every frame whose ninth bit is 0, so that a node on a shared bus is only woken by address frames.

Top module: `uart_rx_filter`

## Requirements
- R1: Frame timing advances only on cycles where `tick` is high, and each bit lasts 16 ticks. The bit counter never passes 16.
- R2: While idle, a low synchronized line seen on a tick counts as tick 1 of a start bit. If the start bit's tick 7/8/9 vote comes out high, the frame is dropped, the receiver goes back to idle, and `rxFlag` stays unchanged.
- R3: Each data bit is the majority of its samples at ticks 7, 8 and 9. A single sample that disagrees does not change the received bit.
- R4: Data bits arrive LSB first. With `nineBitMode`=0 a frame carries 8 data bits. With `nineBitMode`=1 it carries 9, and the 9th goes to `ninthBit`. In 8-bit mode `ninthBit` keeps its old value.
- R5: At tick 9 of the stop bit, if `rxFlag` is 0 and the frame is accepted, `rxData` (and `ninthBit` in 9-bit mode) are loaded and `rxFlag` is set. The value of the stop bit is not checked.
- R6: If `rxFlag` is already 1 when a frame completes, `rxData`, `ninthBit` and `rxFlag` are left unchanged (overrun).
- R7: With `nineBitMode`=1 and `filterEn`=1, a frame whose ninth bit is 0 neither sets `rxFlag` nor updates the holding registers. `filterEn` has no effect when `nineBitMode`=0.
- R8: While `rxEnable` is 0 the receiver is held idle and ignores the line. A frame that `rxEnable` going low cuts off is discarded.
- R9: A high `flagClear` clears `rxFlag` on the next edge. A frame that completes in the same cycle while `rxFlag` is 0 takes precedence.
- R10: After reset `rxData`=0, `ninthBit`=0 and `rxFlag`=0.
- R11: The line passes through a two-flop synchronizer. The receiver returns to idle at the end of the stop bit, so a frame that follows directly is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| rxEnable | input | 1 | Receive enable; 0 holds the receiver idle |
| nineBitMode | input | 1 | 0: 8 data bits, 1: 9 data bits |
| filterEn | input | 1 | Address filter (9-bit mode only) |
| flagClear | input | 1 | Clears the receive-done flag |
| rxData | output | 8 | Holding register for the received byte |
| ninthBit | output | 1 | Received ninth data bit |
| rxFlag | output | 1 | Receive-done flag |

## Verification
The assertions check on every cycle that the bit counter stays within range, that idle is left only on a tick, and that a low `rxEnable` forces idle. They also check that the flag rises only after a completion strobe, that an overrun leaves the holding registers untouched, and that a flag raised under the filter carries a ninth bit of 1. Only the bench's frames can show what is actually received: the bit order, the majority vote tolerating a glitch, the rejection of a short false start, a frame discarded by disabling, and how frames with and without the filter are accepted or dropped, all in both frame lengths.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;

  // Strobes from control to datapath, each one clock wide
  typedef struct packed {
    logic sampleA;   // capture first vote sample
    logic sampleB;   // capture second vote sample
    logic shiftBit;  // shift voted data bit in
    logic complete;  // stop bit reached its vote tick
  } rx_strobe_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int TICKS     = 16,
  parameter int DATA_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxEnable,
  input  logic       nineBitMode,
  input  logic       rxSync,
  input  logic       vote,
  output rx_strobe_t strobe
);

  localparam int CW    = $clog2(TICKS + 1);
  localparam int BCW   = $clog2(DATA_BITS + 1);
  localparam int S_LO  = TICKS / 2 - 1;
  localparam int S_MID = TICKS / 2;
  localparam int S_HI  = TICKS / 2 + 1;

  rx_state_t      state;
  logic [CW-1:0]  tickCnt;
  logic [BCW-1:0] bitCnt;
  logic [CW-1:0]  nextCnt;
  logic           busy;
  logic           lastBit;

  always_comb begin
    nextCnt = (tickCnt == CW'(TICKS)) ? CW'(1) : tickCnt + CW'(1);
    busy    = (state != ST_IDLE);
    lastBit = (bitCnt == (nineBitMode ? BCW'(DATA_BITS) : BCW'(DATA_BITS - 1)));
    strobe.sampleA  = tick && busy && (nextCnt == CW'(S_LO));
    strobe.sampleB  = tick && busy && (nextCnt == CW'(S_MID));
    strobe.shiftBit = tick && (state == ST_DATA) && (nextCnt == CW'(S_HI));
    strobe.complete = tick && (state == ST_STOP) && (nextCnt == CW'(S_HI));
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rxEnable) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (tick) begin
      unique case (state)
        ST_IDLE: begin
          if (!rxSync) begin
            state   <= ST_START;
            tickCnt <= CW'(1);
            bitCnt  <= '0;
          end
        end
        ST_START: begin
          tickCnt <= nextCnt;
          if (nextCnt == CW'(S_HI) && vote) begin
            state   <= ST_IDLE;
            tickCnt <= '0;
          end else if (nextCnt == CW'(TICKS)) begin
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          tickCnt <= nextCnt;
          if (nextCnt == CW'(TICKS)) begin
            if (lastBit) state <= ST_STOP;
            else         bitCnt <= bitCnt + BCW'(1);
          end
        end
        ST_STOP: begin
          tickCnt <= nextCnt;
          if (nextCnt == CW'(TICKS)) begin
            state   <= ST_IDLE;
            tickCnt <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: bit-period counter bounded
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= CW'(TICKS));

  // R1: idle is left only on a tick
  a_r1_idle_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !tick) |=> (state == ST_IDLE));

  // R8: disabled receiver is idle
  a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (state == ST_IDLE));

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  logic                 nineBitMode,
  input  logic                 filterEn,
  input  logic                 flagClear,
  input  rx_strobe_t           strobe,
  output logic                 rxSync,
  output logic                 vote,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 ninthBit,
  output logic                 rxFlag
);

  localparam int SW = DATA_BITS + 1;

  logic                 syncA;
  logic                 sampA;
  logic                 sampB;
  logic [SW-1:0]        shiftReg;
  logic [DATA_BITS-1:0] frameData;
  logic                 frameNinth;
  logic                 accept;
  logic                 load;

  // R11: two-flop synchronizer, idle high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA  <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      syncA  <= rxLine;
      rxSync <= syncA;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampA <= 1'b1;
      sampB <= 1'b1;
    end else begin
      if (strobe.sampleA) sampA <= rxSync;
      if (strobe.sampleB) sampB <= rxSync;
    end
  end

  always_comb begin
    vote       = (sampA & sampB) | (sampA & rxSync) | (sampB & rxSync);
    frameData  = nineBitMode ? shiftReg[DATA_BITS-1:0] : shiftReg[DATA_BITS:1];
    frameNinth = shiftReg[DATA_BITS];
    accept     = !(nineBitMode && filterEn && !frameNinth);
    load       = strobe.complete && !rxFlag && accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftBit) shiftReg <= {vote, shiftReg[SW-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData   <= '0;
      ninthBit <= 1'b0;
      rxFlag   <= 1'b0;
    end else begin
      if (load) begin
        rxData <= frameData;
        if (nineBitMode) ninthBit <= frameNinth;
      end
      if (load)           rxFlag <= 1'b1;
      else if (flagClear) rxFlag <= 1'b0;
    end
  end

  // R5: flag only rises after a completed frame
  a_r5_flag_from_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFlag) |-> $past(strobe.complete));

  // R6: overrun leaves holding registers untouched
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.complete && rxFlag) |=> ($stable(rxData) && $stable(ninthBit) && rxFlag));

  // R7: a flag raised under the filter carries ninth bit 1
  a_r7_filter_addr: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxFlag) && $past(nineBitMode && filterEn)) |-> ninthBit);

  // R9: clear without competing completion drops the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !strobe.complete) |=> !rxFlag);

endmodule

// File: rtl/uart_rx_filter.sv
module uart_rx_filter
  import uart_rx_pkg::*;
#(
  parameter int TICKS     = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 rxLine,
  input  logic                 rxEnable,
  input  logic                 nineBitMode,
  input  logic                 filterEn,
  input  logic                 flagClear,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 ninthBit,
  output logic                 rxFlag
);

  rx_strobe_t strobe;
  logic       rxSync;
  logic       vote;

  uart_rx_ctrl #(.TICKS(TICKS), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .rxEnable    (rxEnable),
    .nineBitMode (nineBitMode),
    .rxSync      (rxSync),
    .vote        (vote),
    .strobe      (strobe)
  );

  uart_rx_dp #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .rxLine      (rxLine),
    .nineBitMode (nineBitMode),
    .filterEn    (filterEn),
    .flagClear   (flagClear),
    .strobe      (strobe),
    .rxSync      (rxSync),
    .vote        (vote),
    .rxData      (rxData),
    .ninthBit    (ninthBit),
    .rxFlag      (rxFlag)
  );

endmodule

// File: tb/sim_uart_rx_filter.sv
module sim_uart_rx_filter;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int GAP_CLKS   = 24;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tick;
  logic       rxLine;
  logic       rxEnable;
  logic       nineBitMode;
  logic       filterEn;
  logic       flagClear;
  logic [7:0] rxData;
  logic       ninthBit;
  logic       rxFlag;

  int checks = 0;
  int errors = 0;

  uart_rx_filter u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .rxLine(rxLine),
    .rxEnable(rxEnable), .nineBitMode(nineBitMode), .filterEn(filterEn),
    .flagClear(flagClear), .rxData(rxData), .ninthBit(ninthBit), .rxFlag(rxFlag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    int divCnt;
    divCnt = 0;
    tick = 1'b0;
    forever begin
      @(negedge clk);
      divCnt = (divCnt + 1) % TICK_DIV;
      tick = (divCnt == 0);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Sends one frame; glitchBit >= 0 flips a short window inside that data bit
  task automatic sendFrame(input logic [8:0] bits, input int nBits, input int glitchBit);
    rxLine = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int b = 0; b < nBits; b++) begin
      for (int k = 0; k < BIT_CLKS; k++) begin
        if (b == glitchBit && k >= 30 && k < 34) rxLine = ~bits[b];
        else rxLine = bits[b];
        @(negedge clk);
      end
    end
    rxLine = 1'b1;
    repeat (BIT_CLKS + GAP_CLKS) @(negedge clk);
  endtask

  task automatic pulseClear();
    flagClear = 1'b1;
    @(negedge clk);
    flagClear = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R10 rxData", int'(rxData), 0);
    check("R10 ninthBit", int'(ninthBit), 0);
    check("R10 rxFlag", int'(rxFlag), 0);
  endtask

  task automatic testEightBit();
    nineBitMode = 1'b0;
    sendFrame(9'h0A5, 8, -1);
    check("R4 R5 byte LSB first", int'(rxData), 'hA5);
    check("R5 flag set", int'(rxFlag), 1);
    check("R4 ninthBit kept in 8-bit", int'(ninthBit), 0);
    pulseClear();
    check("R9 flag cleared", int'(rxFlag), 0);
    // R11: back-to-back frame right after the stop bit
    sendFrame(9'h03C, 8, -1);
    check("R11 second frame", int'(rxData), 'h3C);
    pulseClear();
  endtask

  task automatic testNineBit();
    nineBitMode = 1'b1;
    sendFrame(9'h1C3, 9, -1);
    check("R4 nine-bit data", int'(rxData), 'hC3);
    check("R4 nine-bit ninth", int'(ninthBit), 1);
    check("R5 nine-bit flag", int'(rxFlag), 1);
  endtask

  task automatic testOverrun();
    // flag still set from previous frame
    sendFrame(9'h055, 9, -1);
    check("R6 data held", int'(rxData), 'hC3);
    check("R6 ninth held", int'(ninthBit), 1);
    check("R6 flag held", int'(rxFlag), 1);
    pulseClear();
    sendFrame(9'h081, 9, -1);
    check("R6 recovers after clear", int'(rxData), 'h81);
    check("R6 ninth after clear", int'(ninthBit), 0);
    pulseClear();
  endtask

  task automatic testFilter();
    nineBitMode = 1'b1;
    filterEn = 1'b1;
    sendFrame(9'h012, 9, -1);
    check("R7 data frame dropped flag", int'(rxFlag), 0);
    check("R7 data frame dropped data", int'(rxData), 'h81);
    sendFrame(9'h134, 9, -1);
    check("R7 address frame flag", int'(rxFlag), 1);
    check("R7 address frame data", int'(rxData), 'h34);
    check("R7 address frame ninth", int'(ninthBit), 1);
    pulseClear();
    nineBitMode = 1'b0;
    sendFrame(9'h056, 8, -1);
    check("R7 filter ignored 8-bit flag", int'(rxFlag), 1);
    check("R7 filter ignored 8-bit data", int'(rxData), 'h56);
    check("R4 ninth unchanged 8-bit", int'(ninthBit), 1);
    filterEn = 1'b0;
    pulseClear();
  endtask

  task automatic testFalseStart();
    nineBitMode = 1'b0;
    rxLine = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    check("R2 false start no flag", int'(rxFlag), 0);
    check("R2 false start data kept", int'(rxData), 'h56);
    sendFrame(9'h0E7, 8, -1);
    check("R2 frame after false start", int'(rxData), 'hE7);
    pulseClear();
  endtask

  task automatic testGlitch();
    nineBitMode = 1'b0;
    sendFrame(9'h0F0, 8, 1);
    check("R3 glitch on zero bit", int'(rxData), 'hF0);
    pulseClear();
    sendFrame(9'h0F0, 8, 6);
    check("R3 glitch on one bit", int'(rxData), 'hF0);
    pulseClear();
  endtask

  task automatic testDisable();
    nineBitMode = 1'b0;
    rxEnable = 1'b0;
    sendFrame(9'h011, 8, -1);
    check("R8 disabled no flag", int'(rxFlag), 0);
    check("R8 disabled data kept", int'(rxData), 'hF0);
    rxEnable = 1'b1;
    // partial frame cut off by disabling
    rxLine = 1'b0;
    repeat (2 * BIT_CLKS) @(negedge clk);
    rxEnable = 1'b0;
    rxLine = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
    rxEnable = 1'b1;
    repeat (12 * BIT_CLKS) @(negedge clk);
    check("R8 partial frame dropped", int'(rxFlag), 0);
    sendFrame(9'h05A, 8, -1);
    check("R8 receive after re-enable", int'(rxData), 'h5A);
    check("R8 flag after re-enable", int'(rxFlag), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    rxLine = 1'b1;
    rxEnable = 1'b1;
    nineBitMode = 1'b0;
    filterEn = 1'b0;
    flagClear = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    testReset();
    testEightBit();
    testNineBit();
    testOverrun();
    testFilter();
    testFalseStart();
    testGlitch();
    testDisable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule